// File: doc/BRIEF.md
# Cascadable presettable binary counter

This block is a synchronous up-counter assembled from identical nibble-wide stages. Each stage counts on the rising clock edge. It can be preset from parallel data and cleared through an active-low clear pin. A parameter fixes whether that clear acts at once or waits for the next rising edge. Two active-high enables control counting. The first, `cnt_en`, goes to every stage. The second, `carry_en`, also gates the terminal-carry output. The top module chains the stages so that each stage's terminal carry drives the carry enable of the stage above it. The whole word therefore counts in lockstep from 0 to 2^(NIB_W*STAGES)-1 and then wraps.

The top-level `carry_out` can feed the `carry_en` of another instance, which builds wider counters from the same block. The ports carry no stream of data, so every pin is a plain level-sensitive control or data signal with no handshake.

Top module: `cnt_chain`

## Requirements
- R1: With `CLR_MODE = CLR_ASYNC`, driving `clr_n` low sets `q` to zero at once, without waiting for a clock edge.
- R2: With `CLR_MODE = CLR_SYNC`, `clr_n` low has no effect on `q` until the next rising edge, and that edge sets `q` to zero.
- R3: Clear has the highest priority. While `clr_n` is low, `q` becomes zero whatever the values of `load_n`, `cnt_en` and `carry_en`.
- R4: When `clr_n` is high and `load_n` is low, the rising edge copies `d` into `q`, whatever the values of `cnt_en` and `carry_en`.
- R5: When `clr_n`, `load_n`, `cnt_en` and `carry_en` are all high, each rising edge adds one to `q`.
- R6: When `clr_n` and `load_n` are high and either `cnt_en` or `carry_en` is low, `q` holds its value.
- R7: `carry_out` is high exactly when `carry_en` is high and every bit of `q` is 1. It is combinational, so lowering `carry_en` drops it within the same cycle.
- R8: Incrementing from all ones wraps `q` to zero.
- R9: The stage at bits [NIB_W*(k+1)-1 : NIB_W*k] advances only on an incrementing edge where every lower stage holds all ones. The chain therefore counts as one binary number.
- R10: Clear, then load 12, then six counting edges produce the sequence 13, 14, 15, 0, 1, 2 on the low nibble. Lowering an enable afterwards holds the value 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; acts at once or on the edge, depending on `CLR_MODE` |
| load_n | input | 1 | Active-low parallel preset |
| cnt_en | input | 1 | Count enable shared by all stages |
| carry_en | input | 1 | Count enable of the lowest stage; also gates `carry_out` |
| d | input | NIB_W*STAGES | Preset value |
| q | output | NIB_W*STAGES | Current count |
| carry_out | output | 1 | Terminal carry: high when `carry_en` is high and `q` is all ones |

## Verification
All of the state appears directly on `q`. A wrong next-state choice, such as a lost increment, a bad priority or a stage that advances without its carry, therefore shows on the port at the first edge after it happens. A wrong carry link between stages shows when the low nibble wraps: the upper nibble either fails to step or steps out of turn on that same edge. A faulty carry gate shows on `carry_out` within the cycle in which `carry_en` or the all-ones count changes. A clear that waits for the edge when it should act at once, or the reverse, is caught by sampling `q` in the middle of a cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // How the active-low clear takes effect.
  typedef enum logic {
    CLR_SYNC  = 1'b0,
    CLR_ASYNC = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/cnt_nib_next.sv
// Next-state selection for one stage: preset beats counting; clear is handled at the register.
module cnt_nib_next #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] cur,
  input  logic [NIB_W-1:0] din,
  input  logic             load_n,
  input  logic             adv,
  output logic [NIB_W-1:0] nxt,
  output logic             full
);
  localparam logic [NIB_W-1:0] ONE = NIB_W'(1);

  always_comb begin
    if (!load_n)  nxt = din;
    else if (adv) nxt = cur + ONE;
    else          nxt = cur;
  end

  assign full = &cur;
endmodule

// File: rtl/cnt_stage.sv
// One nibble stage: state register plus terminal-carry gate.
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int        NIB_W    = 4,
  parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             carry_en,
  input  logic [NIB_W-1:0] d,
  output logic [NIB_W-1:0] q,
  output logic             carry_out
);
  logic [NIB_W-1:0] nxt;
  logic             full;

  cnt_nib_next #(.NIB_W(NIB_W)) next_i (
    .cur    (q),
    .din    (d),
    .load_n (load_n),
    .adv    (cnt_en & carry_en),
    .nxt    (nxt),
    .full   (full)
  );

  generate
    if (CLR_MODE == CLR_ASYNC) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sclr
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate

  assign carry_out = carry_en & full;
endmodule

// File: rtl/cnt_chain.sv
// Top: STAGES nibble counters, each stage's carry feeding the next stage's carry enable.
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int        NIB_W    = 4,
  parameter int        STAGES   = 2,
  parameter clr_mode_e CLR_MODE = CLR_ASYNC,
  localparam int       W        = NIB_W * STAGES
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         cnt_en,
  input  logic         carry_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         carry_out
);
  logic [STAGES:0] t_link;

  assign t_link[0] = carry_en;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      cnt_stage #(.NIB_W(NIB_W), .CLR_MODE(CLR_MODE)) stage_i (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .cnt_en    (cnt_en),
        .carry_en  (t_link[k]),
        .d         (d[k*NIB_W +: NIB_W]),
        .q         (q[k*NIB_W +: NIB_W]),
        .carry_out (t_link[k+1])
      );
    end
  endgenerate

  assign carry_out = t_link[STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk
  import cnt_pkg::*;
#(
  parameter int        NIB_W    = 4,
  parameter int        W        = 8,
  parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic         cnt_en,
  input logic         carry_en,
  input logic [W-1:0] d,
  input logic [W-1:0] q,
  input logic         carry_out
);
  localparam logic [W-1:0] ONE = W'(1);

  // Goes high after the first edge so that no check sees pre-clock values.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  generate
    if (CLR_MODE == CLR_ASYNC) begin : g_a
      assert_clr_now_R1: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |-> q == '0);
    end else begin : g_s
      assert_clr_edge_R2: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> q == '0);
    end
  endgenerate

  assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n || !armed)
    !load_n |=> q == $past(d));

  assert_inc_R5: assert property (@(posedge clk) disable iff (!clr_n || !armed)
    load_n && cnt_en && carry_en |=> q == $past(q) + ONE);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!clr_n || !armed)
    load_n && !(cnt_en && carry_en) |=> $stable(q));

  assert_carry_R7: assert property (@(posedge clk) disable iff (!armed)
    carry_out == (carry_en && (q == '1)));

  assert_upper_hold_R9: assert property (@(posedge clk) disable iff (!clr_n || !armed)
    load_n && (q[NIB_W-1:0] != '1) |=> $stable(q[W-1:NIB_W]));
endmodule

bind cnt_chain cnt_chain_chk #(.NIB_W(NIB_W), .W(W), .CLR_MODE(CLR_MODE)) chk_i (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .carry_en  (carry_en),
  .d         (d),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/cnt_chain_tb_top.sv
`timescale 1ns/1ps
module cnt_chain_tb_top;
  import cnt_pkg::*;

  localparam int NIB = 4;
  localparam int STG = 2;
  localparam int W   = NIB * STG;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         clr_n = 1'b0;
  logic         load_n = 1'b1;
  logic         cnt_en = 1'b0;
  logic         carry_en = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q_a, q_s;
  logic         co_a, co_s;

  cnt_chain #(.NIB_W(NIB), .STAGES(STG), .CLR_MODE(CLR_ASYNC)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .d(d), .q(q_a), .carry_out(co_a));

  cnt_chain #(.NIB_W(NIB), .STAGES(STG), .CLR_MODE(CLR_SYNC)) dut_s (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .d(d), .q(q_s), .carry_out(co_s));

  int m_a = 0;
  int m_s = 0;
  int total = 0;
  int bad = 0;

  function automatic int model_next(int m);
    if (!clr_n)                   return 0;
    else if (!load_n)             return int'(d);
    else if (cnt_en && carry_en)  return (m + 1) % (MAXV + 1);
    else                          return m;
  endfunction

  always @(posedge clk) begin
    m_a = model_next(m_a);
    m_s = model_next(m_s);
  end

  always @(negedge clr_n) m_a = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " async q"}, 16'(q_a), 16'(m_a));
    chk({tag, " sync q"}, 16'(q_s), 16'(m_s));
    chk({tag, " async carry"}, 16'(co_a), 16'(carry_en && m_a == MAXV));
    chk({tag, " sync carry"}, 16'(co_s), 16'(carry_en && m_s == MAXV));
  endtask

  task automatic apply(bit c, bit l, bit p, bit t, logic [W-1:0] dv, string tag);
    clr_n = c; load_n = l; cnt_en = p; carry_en = t; d = dv;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] lf;
    @(negedge clk);
    // Reset state and clear priority
    apply(0, 1, 1, 1, 8'h00, "R3");
    apply(0, 1, 1, 1, 8'h00, "R3");
    apply(0, 0, 1, 1, 8'hAA, "R3");

    // Reference sequence
    apply(1, 0, 0, 0, 8'h0C, "R10");
    for (int k = 0; k < 6; k++) begin
      apply(1, 1, 1, 1, 8'h00, "R10");
      chk("R10 low nibble", 16'(q_a[NIB-1:0]), 16'((13 + k) % 16));
    end
    apply(1, 1, 0, 1, 8'h00, "R10");
    chk("R10 inhibit", 16'(q_a[NIB-1:0]), 16'd2);

    // Load ignores the enables
    apply(1, 0, 0, 0, 8'h5A, "R4");
    apply(1, 0, 1, 1, 8'hC3, "R4");
    apply(1, 0, 1, 0, 8'h77, "R4");
    chk("R4 explicit", 16'(q_s), 16'h77);

    // Hold when either enable is low
    apply(1, 1, 0, 0, 8'h00, "R6");
    apply(1, 1, 1, 0, 8'h00, "R6");
    apply(1, 1, 0, 1, 8'h00, "R6");
    chk("R6 explicit", 16'(q_a), 16'h77);

    // Increment
    apply(1, 1, 1, 1, 8'h00, "R5");
    apply(1, 1, 1, 1, 8'h00, "R5");
    chk("R5 explicit", 16'(q_a), 16'h79);

    // Terminal carry, combinational drop
    apply(1, 0, 0, 1, 8'hFF, "R7");
    chk("R7 carry high", 16'(co_a), 16'd1);
    #1 carry_en = 1'b0;
    #0.5 chk("R7 carry drops at once", 16'(co_a), 16'd0);
    chk("R7 carry drops at once sync", 16'(co_s), 16'd0);
    @(negedge clk);
    check_all("R7");

    // Wrap
    apply(1, 1, 1, 1, 8'h00, "R8");
    chk("R8 wrap", 16'(q_s), 16'd0);

    // Cascade
    apply(1, 0, 0, 0, 8'h0F, "R9");
    apply(1, 1, 1, 1, 8'h00, "R9");
    chk("R9 upper steps", 16'(q_a), 16'h10);
    apply(1, 0, 0, 0, 8'h3E, "R9");
    apply(1, 1, 1, 1, 8'h00, "R9");
    apply(1, 1, 1, 1, 8'h00, "R9");
    chk("R9 carry into upper", 16'(q_a), 16'h40);
    for (int k = 0; k < 260; k++) apply(1, 1, 1, 1, 8'h00, "R9");

    // Clear asserted in the middle of a cycle
    apply(1, 0, 0, 0, 8'h40, "R1");
    apply(1, 1, 1, 1, 8'h00, "R1");
    #1 clr_n = 1'b0;
    #0.5 chk("R1 immediate clear", 16'(q_a), 16'd0);
    chk("R2 no clear before edge", 16'(q_s), 16'h41);
    @(negedge clk);
    check_all("R2");
    chk("R2 cleared on edge", 16'(q_s), 16'd0);
    apply(1, 1, 1, 1, 8'h00, "R5");

    // Every control combination, both modes
    lf = 8'hA5;
    for (int rep = 0; rep < 6; rep++) begin
      for (int cmb = 0; cmb < 16; cmb++) begin
        string tg;
        lf = {lf[W-2:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        if (!cmb[3])                tg = "R3";
        else if (!cmb[2])           tg = "R4";
        else if (cmb[1] && cmb[0])  tg = "R5";
        else                        tg = "R6";
        apply(cmb[3], cmb[2], cmb[1], cmb[0], lf, tg);
        if (rep[0]) apply(1, 1, 1, 1, 8'h00, "R5");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule